// File: doc/BRIEF.md
# Prioritized 64-Input Interrupt Controller

This block gathers 64 level-sensitive request lines from peripherals and drives two processor interrupt inputs, a fast one (FIQ) and a normal one (IRQ). Each line can be masked on its own. Each line is steered to one of the two outputs by a per-line select bit. The controller never latches or clears a request: a request stays visible until its peripheral drops the line.

The upper half of the inputs (32 to 63) can be individually raised into an error class. A pending, enabled error-class line beats every other line of its output group, whatever its position. Otherwise the lowest-numbered pending enabled line wins. Software reads the winning index of each group from a read-only register, so an interrupt handler can dispatch without scanning the status words.

Software sees the block through a single-cycle word-addressed register port with registered read data. Every request line passes through a two-flop synchronizer before any logic uses it.

Top module: `intc_top`

## Requirements
- R1: After reset the enable, error-class and FIQ-select registers all read 0, and irq_o and fiq_o stay low even while every request line is high.
- R2: Address 0x0 bit k enables input k, and address 0x1 bit k enables input 32+k (1 enables, 0 disables). A disabled input never raises irq_o or fiq_o. Writing 0x0000000A to address 0x0 enables only inputs 1 and 3 of the lower half.
- R3: Address 0x2 reads input k at bit k, and address 0x3 reads input 32+k at bit k. Each bit is the synchronized line level ANDed with its enable.
- R4: There is no clear mechanism. A status bit, and the output it drives, falls only when its request line falls.
- R5: Address 0x5 bit k (input k) and address 0x6 bit k (input 32+k) route the input to fiq_o when 1 and to irq_o when 0. Each output is the OR of its group's enabled, pending inputs.
- R6: Address 0x4 bit k puts input 32+k in the error class. A pending, enabled error-class input wins its group over any non-error input, including lower-numbered ones.
- R7: Within a group, the lowest-numbered pending input wins. Among several error-class inputs, the lowest-numbered one wins.
- R8: Address 0x7 (IRQ group) and address 0x8 (FIQ group) read the winner as bit 31 = valid and bits 5:0 = index, with all other bits 0. The whole word is 0 when nothing in the group is pending.
- R9: Writes to the read-only addresses 0x2, 0x3, 0x7 and 0x8 change no state. Reads of unmapped addresses return 0.
- R10: A change on a request line reaches irq_o and fiq_o two clock edges after it is first sampled. Read data appears on the edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 64 | Level-sensitive request lines, asynchronous |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
A wrong enable, select or error-class bit becomes visible two edges after a matching request line is high. It shows as a wrongly asserted or missing irq_o or fiq_o, or as a wrong index in the 0x7 and 0x8 words one read later. A corrupted synchronizer stage shows as a status word that lags by more or less than two edges, or that holds a level the line no longer drives. Priority faults only appear when two or more lines are pending in the same group at once, so the stimulus stacks low-numbered normal lines against higher-numbered error-class lines in both groups.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    ADDR_EN_LO   = 4'h0,
    ADDR_EN_HI   = 4'h1,
    ADDR_ST_LO   = 4'h2,
    ADDR_ST_HI   = 4'h3,
    ADDR_ERR     = 4'h4,
    ADDR_FSEL_LO = 4'h5,
    ADDR_FSEL_HI = 4'h6,
    ADDR_IDX_IRQ = 4'h7,
    ADDR_IDX_FIQ = 4'h8
  } reg_addr_e;

  localparam int GRP_IRQ = 0;
  localparam int GRP_FIQ = 1;
  localparam int N_GRP   = 2;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  err_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] hot;
  logic [N-1:0] cand;

  // error-class requests shadow all others
  assign hot  = req_i & err_i;
  assign cand = (|hot) ? hot : req_i;
  assign vld_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N-1; i >= 0; i--)
      if (cand[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*DW-1:0]     irq_src_i,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);
  localparam int NS = 2*DW;
  localparam int IW = $clog2(NS);

  logic [NS-1:0] src_s;
  logic [NS-1:0] en_q, fsel_q;
  logic [DW-1:0] err_q;
  logic [NS-1:0] err_full;
  logic [NS-1:0] grp_pend [N_GRP];
  logic          grp_vld  [N_GRP];
  logic [IW-1:0] grp_idx  [N_GRP];
  logic [NS-1:0] irq_pend, fiq_pend;
  logic          irq_vld, fiq_vld;
  logic [IW-1:0] irq_idx, fiq_idx;
  logic [NS-1:0] status;
  logic [DW-1:0] rd_d;

  intc_sync #(.W(NS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_src_i),
    .q_o   (src_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      fsel_q <= '0;
      err_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_EN_LO:   en_q[DW-1:0]    <= wdata_i;
        ADDR_EN_HI:   en_q[NS-1:DW]   <= wdata_i;
        ADDR_ERR:     err_q           <= wdata_i;
        ADDR_FSEL_LO: fsel_q[DW-1:0]  <= wdata_i;
        ADDR_FSEL_HI: fsel_q[NS-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign err_full = {err_q, {DW{1'b0}}};
  assign status   = src_s & en_q;
  assign irq_pend = status & ~fsel_q;
  assign fiq_pend = status & fsel_q;

  assign grp_pend[GRP_IRQ] = irq_pend;
  assign grp_pend[GRP_FIQ] = fiq_pend;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    intc_prio #(.N(NS), .IW(IW)) i_prio (
      .req_i(grp_pend[g]),
      .err_i(err_full),
      .vld_o(grp_vld[g]),
      .idx_o(grp_idx[g])
    );
  end

  assign irq_vld = grp_vld[GRP_IRQ];
  assign fiq_vld = grp_vld[GRP_FIQ];
  assign irq_idx = grp_idx[GRP_IRQ];
  assign fiq_idx = grp_idx[GRP_FIQ];

  assign irq_o = |irq_pend;
  assign fiq_o = |fiq_pend;

  always_comb begin
    rd_d = '0;
    case (addr_i)
      ADDR_EN_LO:   rd_d = en_q[DW-1:0];
      ADDR_EN_HI:   rd_d = en_q[NS-1:DW];
      ADDR_ST_LO:   rd_d = status[DW-1:0];
      ADDR_ST_HI:   rd_d = status[NS-1:DW];
      ADDR_ERR:     rd_d = err_q;
      ADDR_FSEL_LO: rd_d = fsel_q[DW-1:0];
      ADDR_FSEL_HI: rd_d = fsel_q[NS-1:DW];
      ADDR_IDX_IRQ: rd_d = {irq_vld, {(DW-1-IW){1'b0}}, irq_vld ? irq_idx : {IW{1'b0}}};
      ADDR_IDX_FIQ: rd_d = {fiq_vld, {(DW-1-IW){1'b0}}, fiq_vld ? fiq_idx : {IW{1'b0}}};
      default:      rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2*DW-1:0]   irq_src_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [2*DW-1:0]   en_q,
  input logic [DW-1:0]     err_q,
  input logic [2*DW-1:0]   irq_pend,
  input logic              irq_vld,
  input logic              fiq_vld,
  input logic [$clog2(2*DW)-1:0] irq_idx
);
  // R2: quiet lines for two edges give quiet outputs
  a_r2_quiet_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_src_i, 2) == '0 && $past(irq_src_i, 1) == '0) |-> (!irq_o && !fiq_o));

  // R2: low enable word takes the written value
  a_r2_en_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(addr_i) == ADDR_EN_LO) |-> en_q[DW-1:0] == $past(wdata_i));

  // R8: the IRQ index valid bit agrees with the IRQ output
  a_r8_irq_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vld == irq_o);

  // R8: the FIQ index valid bit agrees with the FIQ output
  a_r8_fiq_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_vld == fiq_o);

  // R6: a non-error winner means no error-class request is pending in the group
  a_r6_err_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_vld && irq_idx < DW) |-> !(|(irq_pend[2*DW-1:DW] & err_q)));

  // R9: a write to a read-only address changes no state
  a_r9_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && ($past(addr_i) == ADDR_ST_LO || $past(addr_i) == ADDR_ST_HI ||
     $past(addr_i) == ADDR_IDX_IRQ || $past(addr_i) == ADDR_IDX_FIQ))
    |-> ($stable(en_q) && $stable(err_q)));
endmodule

bind intc_top intc_checker #(.DW(DW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_src_i(irq_src_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .en_q     (en_q),
  .err_q    (err_q),
  .irq_pend (irq_pend),
  .irq_vld  (irq_vld),
  .fiq_vld  (fiq_vld),
  .irq_idx  (irq_idx)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  import intc_pkg::*;

  typedef struct packed {
    logic [31:0] en_lo, en_hi, err, fs_lo, fs_hi;
    logic [63:0] src;
    logic [31:0] irq_x, fiq_x;
    logic        irq, fiq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000000A, 32'h0, 32'h0, 32'h0, 32'h0, {64{1'b1}}, 32'h80000001, 32'h0, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 64'h0000_0100_0000_0020, 32'h80000005, 32'h0, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000100, 32'h0, 32'h0, 64'h0000_0100_0000_0020, 32'h80000028, 32'h0, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00040100, 32'h0, 32'h0, 64'h0004_0100_0000_0020, 32'h80000028, 32'h0, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h00000020, 32'h0, 64'h0000_0100_0000_0020, 32'h80000028, 32'h80000005, 1'b1, 1'b1},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, {64{1'b1}}, 32'h0, 32'h0, 1'b0, 1'b0},
    '{32'h0, 32'h80000000, 32'h0, 32'h0, 32'h80000000, {64{1'b1}}, 32'h0, 32'h8000003F, 1'b0, 1'b1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 64'h8000_0000_0000_0001, 32'h8000003F, 32'h0, 1'b1, 1'b0}
  };
  localparam string VREQ [NV] = '{"R2", "R7", "R6", "R7", "R5", "R2", "R8", "R6"};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_src_i = '1;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  intc_top i_intc_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R10 watchdog act=%0d exp=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    @(negedge clk_i);
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  logic [31:0] rv;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    // R1 reset state
    chk("R1 irq_o", irq_o, 1'b0);
    chk("R1 fiq_o", fiq_o, 1'b0);
    rd(ADDR_EN_LO, rv);   chk("R1 en_lo", rv, 0);
    rd(ADDR_EN_HI, rv);   chk("R1 en_hi", rv, 0);
    rd(ADDR_ERR, rv);     chk("R1 err", rv, 0);
    rd(ADDR_FSEL_HI, rv); chk("R1 fsel_hi", rv, 0);
    rd(ADDR_IDX_IRQ, rv); chk("R8 idx idle", rv, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(ADDR_EN_LO, VECS[v].en_lo);
      wr(ADDR_EN_HI, VECS[v].en_hi);
      wr(ADDR_ERR, VECS[v].err);
      wr(ADDR_FSEL_LO, VECS[v].fs_lo);
      wr(ADDR_FSEL_HI, VECS[v].fs_hi);
      @(negedge clk_i);
      irq_src_i = VECS[v].src;
      settle();
      chk({VREQ[v], " irq_o"}, irq_o, VECS[v].irq);
      chk({VREQ[v], " fiq_o"}, fiq_o, VECS[v].fiq);
      rd(ADDR_IDX_IRQ, rv); chk({VREQ[v], " irq idx"}, rv, VECS[v].irq_x);
      rd(ADDR_IDX_FIQ, rv); chk({VREQ[v], " fiq idx"}, rv, VECS[v].fiq_x);
      rd(ADDR_ST_LO, rv);   chk("R3 status lo", rv, VECS[v].src[31:0] & VECS[v].en_lo);
      rd(ADDR_ST_HI, rv);   chk("R3 status hi", rv, VECS[v].src[63:32] & VECS[v].en_hi);
    end

    // R9: read-only writes ignored, unmapped reads zero
    wr(ADDR_EN_LO, 32'h0000000A);
    wr(ADDR_EN_HI, 32'h0);
    wr(ADDR_FSEL_LO, 32'h0);
    @(negedge clk_i); irq_src_i = '0;
    settle();
    wr(ADDR_ST_LO, 32'hFFFFFFFF);
    wr(ADDR_IDX_IRQ, 32'hFFFFFFFF);
    rd(ADDR_ST_LO, rv);   chk("R9 status unwritten", rv, 0);
    rd(ADDR_EN_LO, rv);   chk("R9 en_lo kept", rv, 32'h0000000A);
    rd(ADDR_IDX_IRQ, rv); chk("R9 idx unwritten", rv, 0);
    rd(4'hF, rv);         chk("R9 unmapped", rv, 0);
    chk("R9 irq_o quiet", irq_o, 1'b0);

    // R10: two-edge input latency
    @(negedge clk_i); irq_src_i = 64'h8;
    @(negedge clk_i); chk("R10 after one edge", irq_o, 1'b0);
    @(negedge clk_i); chk("R10 after two edges", irq_o, 1'b1);

    // R4: level held, no clear, drops with the line
    wr(ADDR_ST_LO, 32'h0);
    rd(ADDR_ST_LO, rv); chk("R4 status held", rv, 32'h8);
    @(negedge clk_i); irq_src_i = '0;
    settle();
    rd(ADDR_ST_LO, rv); chk("R4 status dropped", rv, 0);
    chk("R4 irq_o dropped", irq_o, 1'b0);

    // R2: disabled line 2 (bit not set in 0xA) is ignored
    @(negedge clk_i); irq_src_i = 64'h4;
    settle();
    chk("R2 disabled line", irq_o, 1'b0);
    rd(ADDR_IDX_IRQ, rv); chk("R2 disabled idx", rv, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule